// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Spread Mode

This block drives four pulse-width outputs from one shared 10-bit cycle counter. The counter moves forward by one step only when the clock-enable input `tick` is high for a clock, so the PWM step rate is set by a prescaler outside the block. Each channel holds a 10-bit width value n. In normal mode the channel output stays high for the first n+1 steps of every 1024-step cycle.

In spread mode the 1024-step cycle is cut into four quadrants of 256 steps. Every quadrant starts with a high stretch of n/4 steps (the width with its two low bits dropped), and the two low bits decide which quadrants get one extra high step. The total high time per cycle is still n+1 steps, but it is split into four shorter pulses. After an external low-pass filter this leaves less ripple. One mode bit applies to all four channels.

Software writes the widths and the mode bit through a simple write port into staging registers. Staged values are copied into the live registers at the step where the counter wraps from 1023 to 0, so a cycle never mixes an old and a new setting.

Top module: `pwm_spread4`

## Requirements
- R1: The shared step counter increases by one, modulo 1024, on each clock where `tick` is high, and holds its value when `tick` is low. The outputs change only when the counter changes.
- R2: In normal mode (mode bit 0), channel output k is high exactly when the counter value is at most the live width n of channel k.
- R3: In spread mode (mode bit 1), the quadrant is counter bits [9:8] and the offset is counter bits [7:0]. Output k is high exactly when the offset is less than n[9:2] plus that quadrant's extra step.
- R4: The extra step of each quadrant, with quadrants numbered 0 to 3, is set by n[1:0] as follows. Quadrant 0 always gets one. Quadrant 1 gets one when n[1:0] is 2 or 3. Quadrant 2 gets one when n[1:0] is 1, 2 or 3. Quadrant 3 gets one only when n[1:0] is 3.
- R5: A width written to channel k affects that channel's output only from the step where the counter wraps from 1023 to 0 (the first `tick` at count 1023 after the write, including a write made in that same clock, which waits one more cycle). Before then the output follows the previous width.
- R6: The mode bit is staged in the same way as the widths. A new mode applies from the next wrap of the counter, for all channels at once.
- R7: Synchronous reset `rst` sets the counter to 0, all staged and live widths to 0 and the mode to normal. While in reset, and at count 0 after reset, all four outputs are high.
- R8: Write decode, on clocks where `wr_en` is high: `wr_addr` 0 to 3 loads `wr_data[9:0]` as the staged width of that channel. Address 4 loads `wr_data[0]` as the staged mode bit. Addresses 5 to 7 change nothing.
- R9: In either mode, each channel is high for exactly n+1 of the 1024 steps of every full cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Step enable from the external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0-3 channel width, 4 mode |
| wr_data | input | 10 | Write data |
| pwm_out | output | 4 | PWM outputs, bit k is channel k |

## Verification
The main risk is that the counter, the live widths or the mode slip out of step with the true cycle position. A counter that skips or double-steps on `tick` moves the edges of every channel at once. The error shows within one step in normal mode, and within one quadrant in spread mode. A live register loaded at the wrong moment changes an edge in the middle of a cycle, before the wrap, so the output differs in the same cycle as the write. A wrong per-quadrant extra step leaves one quadrant pulse off by one step. It also shows as a wrong high-step total when the bench counts the whole cycle.

// File: rtl/pwm_spread_pkg.sv
package pwm_spread_pkg;

    localparam int DEF_CNT_W = 10;
    localparam int DEF_NUM_CH = 4;

    typedef enum logic {
        PWM_NORMAL = 1'b0,
        PWM_SPREAD = 1'b1
    } pwm_mode_e;

    // Whether a quadrant gains one extra high step, chosen by the two
    // low width bits; quadrant 0 always gains one.
    function automatic logic quad_extra(input logic [1:0] low_bits,
                                        input logic [1:0] quad);
        logic r;
        unique case (quad)
            2'd0: r = 1'b1;
            2'd1: r = low_bits[1];
            2'd2: r = (low_bits != 2'd0);
            default: r = (low_bits == 2'd3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign wrap = tick && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_width_bank.sv
module pwm_width_bank
    import pwm_spread_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         wrap,
    output logic [NUM_CH-1:0][CNT_W-1:0] act_w,
    output pwm_mode_e                    act_mode
);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_CH);

    logic [NUM_CH-1:0][CNT_W-1:0] stg_w;
    pwm_mode_e                    stg_mode;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(ch);

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_w[ch] <= '0;
                act_w[ch] <= '0;
            end else begin
                if (wr_en && wr_addr == CH_ADDR) begin
                    stg_w[ch] <= wr_data;
                end
                if (wrap) begin
                    act_w[ch] <= stg_w[ch];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_mode <= PWM_NORMAL;
            act_mode <= PWM_NORMAL;
        end else begin
            if (wr_en && wr_addr == MODE_ADDR) begin
                stg_mode <= pwm_mode_e'(wr_data[0]);
            end
            if (wrap) begin
                act_mode <= stg_mode;
            end
        end
    end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_spread_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] width,
    input  pwm_mode_e        mode,
    output logic             out
);
    localparam int QW = CNT_W - 2;

    logic [1:0]    quad;
    logic [QW-1:0] offset;
    logic [QW:0]   quad_len;
    logic          normal_hi;
    logic          spread_hi;

    assign quad      = cnt[CNT_W-1 -: 2];
    assign offset    = cnt[QW-1:0];
    assign quad_len  = {1'b0, width[CNT_W-1:2]}
                     + {{QW{1'b0}}, quad_extra(width[1:0], quad)};
    assign normal_hi = (cnt <= width);
    assign spread_hi = ({1'b0, offset} < quad_len);
    assign out       = (mode == PWM_SPREAD) ? spread_hi : normal_hi;
endmodule

// File: rtl/pwm_spread4.sv
module pwm_spread4
    import pwm_spread_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [CNT_W-1:0]             cnt;
    logic                         wrap;
    logic [NUM_CH-1:0][CNT_W-1:0] act_w;
    pwm_mode_e                    act_mode;

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cnt  (cnt),
        .wrap (wrap)
    );

    pwm_width_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wrap     (wrap),
        .act_w    (act_w),
        .act_mode (act_mode)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slice
        pwm_slice #(.CNT_W(CNT_W)) u_slice (
            .cnt   (cnt),
            .width (act_w[ch]),
            .mode  (act_mode),
            .out   (pwm_out[ch])
        );
    end
endmodule

// File: rtl/pwm_spread4_chk.sv
module pwm_spread4_chk
    import pwm_spread_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         tick,
    input logic [CNT_W-1:0]             cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_w,
    input pwm_mode_e                    act_mode,
    input logic [NUM_CH-1:0]            pwm_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1

    AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(tick && cnt == CNT_MAX) |=> $stable(act_w)); // R5

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(tick && cnt == CNT_MAX) |=> $stable(act_mode)); // R6

    AST_CYCLE_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        cnt == '0 |-> &pwm_out); // R4

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_full
        AST_FULL_WIDTH_HIGH: assert property (@(posedge clk) disable iff (rst)
            (act_mode == PWM_NORMAL && act_w[ch] == CNT_MAX) |-> pwm_out[ch]); // R2
    end
endmodule

bind pwm_spread4 pwm_spread4_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt      (cnt),
    .act_w    (act_w),
    .act_mode (act_mode),
    .pwm_out  (pwm_out)
);

// File: tb/test_pwm_spread4.sv
module test_pwm_spread4;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic [3:0] pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    string tag = "R7";

    // behavioural reference state
    int m_cnt = 0;
    int m_pend[NCH];
    int m_act[NCH];
    int m_pmode = 0;
    int m_mode = 0;
    int hi_cnt[NCH];

    pwm_spread4 i_pwm_spread4 (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pmode = 0; m_mode = 0;
            for (int i = 0; i < NCH; i++) begin
                m_pend[i] = 0; m_act[i] = 0; hi_cnt[i] = 0;
            end
        end else begin
            if (tick) begin
                if (m_cnt == 1023) begin
                    for (int i = 0; i < NCH; i++) m_act[i] = m_pend[i];
                    m_mode = m_pmode;
                end
                m_cnt = (m_cnt + 1) % 1024;
            end
            if (wr_en) begin
                if (wr_addr < 4) m_pend[wr_addr] = int'(wr_data);
                else if (wr_addr == 4) m_pmode = int'(wr_data[0]);
            end
        end
    end

    function automatic bit ref_bit(int n, int mode, int c);
        int q, off, lo, ex;
        if (mode == 0) return (c <= n);
        q = c / 256; off = c % 256; lo = n % 4;
        case (q)
            0: ex = 1;
            1: ex = (lo >= 2) ? 1 : 0;
            2: ex = (lo >= 1) ? 1 : 0;
            default: ex = (lo == 3) ? 1 : 0;
        endcase
        return (off < n / 4 + ex);
    endfunction

    task automatic compare();
        for (int i = 0; i < NCH; i++) begin
            bit e;
            e = ref_bit(m_act[i], m_mode, m_cnt);
            n_checks++;
            if (pwm_out[i] !== e) begin
                n_fail++;
                $display("FAIL %s ch%0d step %0d mode %0d: got %b expected %b",
                         tag, i, m_cnt, m_mode, pwm_out[i], e);
            end
        end
    endtask

    // One clock: check outputs, then drive inputs for the next edge.
    task automatic step(input bit t, input bit we, input int a, input int d);
        @(negedge clk);
        compare();
        tick = t; wr_en = we; wr_addr = 3'(a); wr_data = 10'(d);
        if (!rst && t) begin
            for (int i = 0; i < NCH; i++) hi_cnt[i] += int'(pwm_out[i]);
            if (m_cnt == 1023) begin
                for (int i = 0; i < NCH; i++) begin
                    n_checks++;
                    if (hi_cnt[i] != m_act[i] + 1) begin
                        n_fail++;
                        $display("FAIL R9 ch%0d: got %0d high steps expected %0d",
                                 i, hi_cnt[i], m_act[i] + 1);
                    end
                    hi_cnt[i] = 0;
                end
            end
        end
    endtask

    task automatic run(input int n, input int every);
        for (int k = 0; k < n; k++) step((k % every) == 0, 1'b0, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R7: reset state, all outputs high at step 0
        tag = "R7";
        rst = 1'b1;
        run(4, 1);
        @(negedge clk);
        rst = 1'b0;
        tick = 1'b0;
        run(3, 1);

        // R2 R8 R9: normal mode with assorted widths
        tag = "R2 R8";
        wr(0, 0); wr(1, 1); wr(2, 511); wr(3, 1023);
        run(2100, 1);

        // R1: sparse ticks, outputs hold between them
        tag = "R1";
        run(3300, 3);

        // R5: mid-cycle write waits for the wrap
        tag = "R5";
        run(300, 1);
        wr(2, 100);
        wr(0, 700);
        run(2100, 1);

        // R6 R3 R4: spread mode, every low-bit pattern
        tag = "R6 R3 R4";
        wr(4, 1); wr(0, 0); wr(1, 1); wr(2, 2); wr(3, 3);
        run(2100, 1);
        wr(0, 253); wr(1, 510); wr(2, 767); wr(3, 1023);
        run(2100, 1);
        wr(0, 4); wr(1, 5); wr(2, 6); wr(3, 7);
        run(2100, 1);

        // R8: unused addresses leave widths and mode untouched
        tag = "R8";
        wr(5, 1023); wr(6, 1022); wr(7, 1);
        run(2100, 1);

        // R6: back to normal mode at the next wrap
        tag = "R6";
        wr(4, 0);
        run(2100, 1);

        finish_run();
    end
endmodule